// File: doc/BRIEF.md
# MDIO Management Interface Master

This block lets software talk to an external Ethernet PHY over the two-wire management bus using clause-22 frames. Software writes one 32-bit command word that carries the operation, target PHY address, target register number and, for writes, the 16-bit data. The block then sends the full frame on the management clock and data lines. When a read frame ends, the block places the returned 16-bit value back into the same word and raises a read-valid flag.

A busy flag in the same word tells software when the bus is free. Software polls that flag low before it issues the next command. A second, independent register holds the 5-bit address of the attached PHY so that software has one place to keep it. The management clock is the system clock divided by an even ratio that is set by a parameter.

Top module: `mdio_master`

## Requirements
- R1: After reset the command word reads 0, the PHY-address register reads 0, the management clock is low and the data output enable is low.
- R2: A command-word write (`reg_sel` = 0) while busy is clear is accepted. From the next cycle, bit 28 (busy) reads 1 and bits [26:0] hold the written value. Busy stays set until the frame has finished on the wire.
- R3: A write command has bit 26 = 0. It sends, MSB first, 32 ones, start 01, opcode 01, the PHY address (word bits [20:16]), the register number (bits [25:21]), turnaround 10 and the 16 data bits (bits [15:0]), with the output enabled for all 64 bits.
- R4: A read command has bit 26 = 1. It sends the same header with opcode 10 and drives only the first 46 bits. The output enable is low from the turnaround bits to the end of the frame. The 16 bits sampled from `mdio_i` during the data phase, MSB first, go into bits [15:0]. At the same time bit 27 (read-valid) is set and busy is cleared.
- R5: A command-word write while busy is set is ignored. The frame on the wire and the word's bits [26:16] keep the values of the first command.
- R6: Accepting a new command clears read-valid.
- R7: The management clock has a period of `CLK_DIV` system clocks and is high for half of them. `mdio_o` changes only on the clock edge where the management clock falls, and `mdio_i` is sampled where it rises.
- R8: A write with `reg_sel` = 1 loads `reg_wdata[4:0]` into the PHY-address register. It ignores the upper bits and leaves the command word unchanged.
- R9: The data output enable is low whenever busy is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | 0 = command word, 1 = PHY-address register |
| reg_wdata | input | 32 | Register write data |
| cmd_rdata | output | 32 | Command/status word readback |
| phy_sel | output | 5 | PHY-address register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Two events can fall in the same cycle. A software write to the command word can land while a frame is still being shifted, and the end of a read can arrive just as software acts on the flags it reads. The bench provokes the first by writing a second, different command one cycle after the first is accepted. It judges the result by comparing the captured 64-bit frame and the word's address, register and opcode fields against the first command only. For the second, the bench issues a write immediately after a completed read and checks that read-valid drops in the same cycle that busy rises. Random reads and writes, each with its own PHY response, are checked bit by bit against frames built by a bench function.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int RELEASE_IDX = 46;   // first bit a read leaves undriven
    localparam int CAPTURE_IDX = 48;   // first data bit of a read
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic [2:0]  spare;
        logic        busy;
        logic        rvalid;
        logic        op_rd;
        logic [4:0]  regn;
        logic [4:0]  phy;
        logic [15:0] data;
    } cmd_word_t;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic        rd,
        input logic [4:0]  phy,
        input logic [4:0]  regn,
        input logic [15:0] wd
    );
        logic [1:0]  opc;
        logic [1:0]  ta;
        logic [15:0] body;
        opc  = rd ? 2'b10 : 2'b01;
        ta   = rd ? 2'b11 : 2'b10;
        body = rd ? 16'hFFFF : wd;
        return {32'hFFFF_FFFF, 2'b01, opc, phy, regn, ta, body};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    assign rise_tick = (cnt == CW'(HALF - 1));
    assign fall_tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= fall_tick ? '0 : cnt + 1'b1;
            if (rise_tick)
                mdc <= 1'b1;
            else if (fall_tick)
                mdc <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  start_rd,
    input  logic [FRAME_BITS-1:0] start_frame,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [15:0]           rdata
);
    seq_state_t            state;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bitcnt;
    logic                  rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
            rd_q    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        shreg  <= start_frame;
                        rd_q   <= start_rd;
                        bitcnt <= '0;
                        state  <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (fall_tick) begin
                        if (bitcnt == CNT_W'(FRAME_BITS)) begin
                            state   <= SEQ_IDLE;
                            mdio_o  <= 1'b1;
                            mdio_oe <= 1'b0;
                            done    <= 1'b1;
                        end else begin
                            mdio_o  <= shreg[FRAME_BITS-1];
                            shreg   <= {shreg[FRAME_BITS-2:0], 1'b1};
                            mdio_oe <= !(rd_q && (bitcnt >= CNT_W'(RELEASE_IDX)));
                            bitcnt  <= bitcnt + 1'b1;
                        end
                    end
                    if (rise_tick && rd_q && (bitcnt > CNT_W'(CAPTURE_IDX)))
                        rdata <= {rdata[14:0], mdio_i};
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic                  reg_sel,
    input  logic [31:0]           reg_wdata,
    input  logic                  seq_done,
    input  logic [15:0]           seq_rdata,
    output cmd_word_t             cmd_q,
    output logic [4:0]            phy_q,
    output logic                  start,
    output logic                  start_rd,
    output logic [FRAME_BITS-1:0] start_frame
);
    logic unused_hi;
    assign unused_hi = ^reg_wdata[31:27];

    assign start       = reg_wr && !reg_sel && !cmd_q.busy;
    assign start_rd    = reg_wdata[26];
    assign start_frame = build_frame(reg_wdata[26], reg_wdata[20:16],
                                     reg_wdata[25:21], reg_wdata[15:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            phy_q <= '0;
        end else begin
            if (reg_wr && reg_sel)
                phy_q <= reg_wdata[4:0];
            if (start) begin
                cmd_q.spare  <= '0;
                cmd_q.busy   <= 1'b1;
                cmd_q.rvalid <= 1'b0;
                cmd_q.op_rd  <= reg_wdata[26];
                cmd_q.regn   <= reg_wdata[25:21];
                cmd_q.phy    <= reg_wdata[20:16];
                cmd_q.data   <= reg_wdata[15:0];
            end else if (seq_done) begin
                cmd_q.busy <= 1'b0;
                if (cmd_q.op_rd) begin
                    cmd_q.rvalid <= 1'b1;
                    cmd_q.data   <= seq_rdata;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] cmd_rdata,
    output logic [4:0]  phy_sel,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    cmd_word_t             cmd_q;
    logic                  rise_tick;
    logic                  fall_tick;
    logic                  start;
    logic                  start_rd;
    logic [FRAME_BITS-1:0] start_frame;
    logic                  seq_done;
    logic [15:0]           seq_rdata;

    mdio_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .seq_done    (seq_done),
        .seq_rdata   (seq_rdata),
        .cmd_q       (cmd_q),
        .phy_q       (phy_sel),
        .start       (start),
        .start_rd    (start_rd),
        .start_frame (start_frame)
    );

    mdio_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_rd    (start_rd),
        .start_frame (start_frame),
        .rise_tick   (rise_tick),
        .fall_tick   (fall_tick),
        .mdio_i      (mdio_i),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .done        (seq_done),
        .rdata       (seq_rdata)
    );

    assign cmd_rdata = cmd_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [31:0] cmd_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R2: busy only rises after a command-word write
    assert_busy_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_rdata[28]) |-> $past(reg_wr && !reg_sel));

    // R5: a command write during busy leaves the command fields alone
    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_rdata[28] && reg_wr && !reg_sel) |=> $stable(cmd_rdata[26:16]));

    // R6: a newly accepted command never shows stale read-valid
    assert_valid_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_rdata[28]) |-> !cmd_rdata[27]);

    // R7: data output moves only with the falling management clock
    assert_out_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (mdio_o != $past(mdio_o)) |-> $fell(mdc));

    // R9: the line is released whenever idle
    assert_idle_release_R9: assert property (@(posedge clk) disable iff (rst)
        !cmd_rdata[28] |-> !mdio_oe);

    // R4: read-valid appears together with the end of busy
    assert_valid_at_end_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_rdata[27]) |-> $fell(cmd_rdata[28]));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        mdio_i = 1'b1;
    logic [31:0] cmd_rdata;
    logic [4:0]  phy_sel;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [63:0] cap_o;
    logic [63:0] cap_oe;

    mdio_master #(.CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .phy_sel(phy_sel),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] wd);
        logic [63:0] f;
        f[63:32] = '1;
        f[31:30] = 2'b01;
        f[29:28] = rd ? 2'b10 : 2'b01;
        f[27:23] = phy;
        f[22:18] = rg;
        f[17:16] = 2'b10;
        f[15:0]  = wd;
        return f;
    endfunction

    function automatic logic [31:0] cmd_of(input bit rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] wd);
        return {5'b0, rd, rg, phy, wd};
    endfunction

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    endtask

    // capture 64 bits at rising mdc; answer data bits after falling mdc
    task automatic capture(input logic [15:0] resp);
        int guard = 0;
        @(posedge mdc);
        while (!mdio_oe && guard < 100) begin
            @(posedge mdc);
            guard++;
        end
        cap_o[63] = mdio_o; cap_oe[63] = mdio_oe;
        for (int k = 1; k < 64; k++) begin
            @(negedge mdc);
            mdio_i = (k >= 48) ? resp[63-k] : 1'b1;
            @(posedge mdc);
            cap_o[63-k] = mdio_o; cap_oe[63-k] = mdio_oe;
        end
        @(negedge mdc);
        mdio_i = 1'b1;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (cmd_rdata[28] && n < 4*DIV) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] resp, input bit intrude);
        logic [63:0] ef;
        logic [31:0] cw;
        cw = cmd_of(rd, phy, rg, wd);
        ef = exp_frame(rd, phy, rg, wd);
        wr(1'b0, cw);
        check(cmd_rdata[28] == 1'b1 && cmd_rdata[26:0] == cw[26:0], "R2 accept",
              {32'b0, cmd_rdata}, {32'b0, cw | 32'h1000_0000});
        check(cmd_rdata[27] == 1'b0, "R6 valid cleared", {63'b0, cmd_rdata[27]}, 64'd0);
        if (intrude) begin
            wr(1'b0, cmd_of(!rd, ~phy, ~rg, ~wd));
            check(cmd_rdata[26:16] == cw[26:16], "R5 fields kept",
                  {53'b0, cmd_rdata[26:16]}, {53'b0, cw[26:16]});
        end
        capture(resp);
        if (rd) begin
            check(cap_o[63:18] == ef[63:18], "R4 read header", cap_o, ef);
            check(cap_oe == {{46{1'b1}}, 18'b0}, "R4 release", cap_oe, {{46{1'b1}}, 18'b0});
        end else begin
            check(cap_o == ef, intrude ? "R5 frame kept" : "R3 write frame", cap_o, ef);
            check(cap_oe == '1, "R3 drive enable", cap_oe, '1);
        end
        check(cmd_rdata[28] == 1'b1, "R2 busy during frame", {63'b0, cmd_rdata[28]}, 64'd1);
        wait_idle();
        check(cmd_rdata[28] == 1'b0 && mdio_oe == 1'b0, "R9 idle after frame",
              {62'b0, cmd_rdata[28], mdio_oe}, 64'd0);
        if (rd)
            check(cmd_rdata[27] && cmd_rdata[15:0] == resp, "R4 read data",
                  {47'b0, cmd_rdata[27], cmd_rdata[15:0]}, {47'b0, 1'b1, resp});
        else
            check(!cmd_rdata[27] && cmd_rdata[15:0] == wd, "R3 word after write",
                  {47'b0, cmd_rdata[27], cmd_rdata[15:0]}, {47'b0, 1'b0, wd});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1, t2;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_rdata == 32'h0 && phy_sel == 5'h0 && mdio_oe == 1'b0, "R1 reset",
              {26'b0, mdio_oe, phy_sel, cmd_rdata}, 64'd0);

        // R7 clock period and duty
        @(posedge mdc); t0 = cyc;
        @(negedge mdc); t1 = cyc;
        @(posedge mdc); t2 = cyc;
        check(t2 - t0 == DIV, "R7 mdc period", 64'(t2 - t0), 64'(DIV));
        check(t1 - t0 == DIV/2, "R7 mdc high time", 64'(t1 - t0), 64'(DIV/2));

        // R8 PHY-address register
        wr(1'b1, 32'hFFFF_FFEA);
        check(phy_sel == 5'h0A && cmd_rdata == 32'h0, "R8 phy reg",
              {27'b0, phy_sel, cmd_rdata}, {27'b0, 5'h0A, 32'h0});

        // directed corners
        run_cmd(1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 1'b0);
        run_cmd(1'b0, 5'd0, 5'd0, 16'h0000, 16'h0000, 1'b0);
        run_cmd(1'b1, 5'd1, 5'd2, 16'h0000, 16'h8001, 1'b0);
        run_cmd(1'b0, 5'd5, 5'd9, 16'hA5C3, 16'h0000, 1'b0);   // R6 after read
        run_cmd(1'b1, 5'd0, 5'd0, 16'h1234, 16'h0000, 1'b0);
        run_cmd(1'b0, 5'd3, 5'd4, 16'h5A5A, 16'h0000, 1'b1);   // R5 write during busy
        run_cmd(1'b1, 5'd17, 5'd30, 16'h0, 16'hBEEF, 1'b1);    // R5 on a read

        check(phy_sel == 5'h0A, "R8 phy reg untouched", {59'b0, phy_sel}, 64'h0A);

        for (int i = 0; i < 6; i++) begin
            run_cmd(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                    16'($urandom), 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule